// File: doc/BRIEF.md
# Per-Core MSI Vector Interrupt Controller

The controller turns message-signalled interrupt writes into per-core pending state. Each write carries all of its routing in the address. A fixed tag in the upper address word marks a write as an interrupt message. The low address word carries an 8-bit vector number and a core identifier. Each accepted message sets one bit in that core's 256-entry pending set. A message that names a core the controller does not have is dropped, and a sticky error flag is raised.

Each core sees one interrupt line. The line is high while the core has any pending vector and the global delivery enable is on. Software on the core services the line through a claim port. A claim returns the highest-numbered pending vector, or an invalid marker when the set is empty. The returned vector's pending bit is cleared at the clock edge that ends the claim. A separate view port exposes the raw pending bits of any core as 64-bit words.

Top module: `msivec_ctrl`

## Requirements
- R1: A message is accepted only when `msi_addr_hi` equals 0x0000_00FD. Any other upper word leaves every pending bit and the error flag unchanged.
- R2: An accepted message sets pending bit `msi_addr_lo[11:4]` of core `msi_addr_lo[27:12]`. The bit is visible from the clock edge that samples the message.
- R3: `view_data` shows vectors 64·`view_word` to 64·`view_word`+63 of core `view_core`. Vector v appears at bit v mod 64 of word v/64.
- R4: While `claim_rd` is high, `claim_data` holds the highest-numbered pending vector of `claim_core` in bits [7:0], with bits [31:8] zero. That vector's pending bit is clear after the edge.
- R5: A claim on a core with nothing pending returns 0x8000_0000, with bit 31 as the invalid flag, and changes no state.
- R6: `irq_o[c]` is high exactly when `deliver_en` is high and core c has at least one pending vector.
- R7: Repeated messages to a vector that is already pending merge into one bit, so a single claim retires them all.
- R8: When a message sets a vector in the same cycle that a claim clears that vector, the vector stays pending. The claim still returns it.
- R9: An accepted-tag message whose core identifier is not below NUM_CORES sets no pending bit. It sets `err_o`, which stays high until reset.
- R10: Reset clears every pending bit and `err_o`.
- R11: Pending capture does not depend on `deliver_en`. Vectors that arrive while delivery is off raise the line as soon as it is turned on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deliver_en | input | 1 | Global delivery enable for the interrupt lines |
| msi_valid | input | 1 | A message write is present this cycle |
| msi_addr_hi | input | 32 | Upper address word of the message |
| msi_addr_lo | input | 24 | Low address bits 27:4: core id in [27:12], vector in [11:4] |
| claim_rd | input | 1 | Claim read strobe |
| claim_core | input | CORE_W | Core whose pending set is claimed |
| claim_data | output | 32 | Claimed vector in [7:0], or bit 31 set when none is pending |
| view_core | input | CORE_W | Core selected for the raw pending view |
| view_word | input | 2 | 64-bit word selected for the view |
| view_data | output | 64 | Raw pending bits of the selected word |
| irq_o | output | NUM_CORES | Per-core interrupt line |
| err_o | output | 1 | Sticky flag for a message to a nonexistent core |

## Verification
The assertions assume a single message and at most one claim per cycle. They also assume claim and view selectors always name an existing core, which the port widths guarantee at the default core count. The stimulus keeps normal traffic on vectors 16 to 255 and leaves the legacy range 0 to 15 alone. It does send messages with a wrong tag and with a core identifier one past the last core. Random claims are mixed with writes so that set and clear collide on the same vector in the same cycle.

// File: rtl/msivec_pkg.sv
package msivec_pkg;
    localparam int VEC_W        = 8;
    localparam int VEC_N        = 1 << VEC_W;
    localparam int WORD_W       = 64;
    localparam int WORDS        = VEC_N / WORD_W;
    localparam int WSEL_W       = $clog2(WORDS);
    localparam int CORE_FIELD_W = 16;
    localparam int LO_W         = CORE_FIELD_W + VEC_W;   // address bits 27:4
    localparam int RESULT_W     = 32;
    localparam int INVALID_BIT  = 31;
    localparam logic [31:0] MSI_TAG = 32'h0000_00FD;

    typedef struct packed {
        logic                    hit;
        logic [CORE_FIELD_W-1:0] core;
        logic [VEC_W-1:0]        vec;
    } msi_fields_t;

    function automatic msi_fields_t split_msi(input logic valid,
                                              input logic [31:0] hi,
                                              input logic [LO_W-1:0] lo);
        msi_fields_t f;
        f.hit  = valid && (hi == MSI_TAG);
        f.core = lo[LO_W-1 -: CORE_FIELD_W];
        f.vec  = lo[VEC_W-1:0];
        return f;
    endfunction

    function automatic logic [RESULT_W-1:0] claim_word(input logic found,
                                                       input logic [VEC_W-1:0] vec);
        logic [RESULT_W-1:0] w;
        w = '0;
        if (found) w[VEC_W-1:0] = vec;
        else       w[INVALID_BIT] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/msivec_decode.sv
module msivec_decode
    import msivec_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              msi_valid,
    input  logic [31:0]       msi_addr_hi,
    input  logic [LO_W-1:0]   msi_addr_lo,
    output logic              set_valid,
    output logic [CORE_W-1:0] set_core,
    output logic [VEC_W-1:0]  set_vec,
    output logic              bad_core
);
    msi_fields_t f;
    logic        in_range;

    always_comb begin
        f         = split_msi(msi_valid, msi_addr_hi, msi_addr_lo);
        in_range  = f.core < CORE_FIELD_W'(NUM_CORES);
        set_valid = f.hit && in_range;
        bad_core  = f.hit && !in_range;
        set_core  = f.core[CORE_W-1:0];
        set_vec   = f.vec;
    end
endmodule

// File: rtl/msivec_bank.sv
module msivec_bank
    import msivec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_idx,
    output logic [VEC_N-1:0] pend_o,
    output logic             any_o
);
    logic [VEC_N-1:0] pend_q;
    logic [VEC_N-1:0] pend_d;

    always_comb begin
        pend_d = pend_q;
        if (clr_en) pend_d[clr_idx] = 1'b0;
        if (set_en) pend_d[set_idx] = 1'b1;   // set applied last: it wins
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_o = pend_q;
    assign any_o  = |pend_q;

    // R4: a claimed vector is gone after the edge unless re-set in the same cycle
    a_r4_claim_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend_q[$past(clr_idx)]);

    // R8 / R7: a message always leaves its vector pending, whatever else happens
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_en |=> pend_q[$past(set_idx)]);
endmodule

// File: rtl/msivec_pick.sv
module msivec_pick
    import msivec_pkg::*;
(
    input  logic [VEC_N-1:0] pend_i,
    output logic             found_o,
    output logic [VEC_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < VEC_N; i++) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = VEC_W'(i);     // later (higher) index overrides
            end
        end
    end
endmodule

// File: rtl/msivec_ctrl.sv
module msivec_ctrl
    import msivec_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 deliver_en,
    input  logic                 msi_valid,
    input  logic [31:0]          msi_addr_hi,
    input  logic [LO_W-1:0]      msi_addr_lo,
    input  logic                 claim_rd,
    input  logic [CORE_W-1:0]    claim_core,
    output logic [RESULT_W-1:0]  claim_data,
    input  logic [CORE_W-1:0]    view_core,
    input  logic [WSEL_W-1:0]    view_word,
    output logic [WORD_W-1:0]    view_data,
    output logic [NUM_CORES-1:0] irq_o,
    output logic                 err_o
);
    logic              set_valid;
    logic [CORE_W-1:0] set_core;
    logic [VEC_W-1:0]  set_vec;
    logic              bad_core;

    msivec_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .msi_valid  (msi_valid),
        .msi_addr_hi(msi_addr_hi),
        .msi_addr_lo(msi_addr_lo),
        .set_valid  (set_valid),
        .set_core   (set_core),
        .set_vec    (set_vec),
        .bad_core   (bad_core)
    );

    logic [VEC_N-1:0]     pend_all [NUM_CORES];
    logic [NUM_CORES-1:0] any_all;
    logic [VEC_N-1:0]     claim_set;
    logic                 pick_found;
    logic [VEC_W-1:0]     pick_idx;

    assign claim_set = pend_all[claim_core];

    msivec_pick u_pick (
        .pend_i (claim_set),
        .found_o(pick_found),
        .idx_o  (pick_idx)
    );

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            msivec_bank u_bank (
                .clk    (clk),
                .rst    (rst),
                .set_en (set_valid && set_core == CORE_W'(c)),
                .set_idx(set_vec),
                .clr_en (claim_rd && pick_found && claim_core == CORE_W'(c)),
                .clr_idx(pick_idx),
                .pend_o (pend_all[c]),
                .any_o  (any_all[c])
            );
            assign irq_o[c] = deliver_en && any_all[c];
        end
    endgenerate

    assign claim_data = claim_word(pick_found, pick_idx);
    assign view_data  = pend_all[view_core][view_word*WORD_W +: WORD_W];

    logic err_q;
    always_ff @(posedge clk) begin
        if (rst)           err_q <= 1'b0;
        else if (bad_core) err_q <= 1'b1;
    end
    assign err_o = err_q;

    // R9: the error flag never drops without reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R9: a bad-core message raises the flag on the next cycle
    a_r9_err_raise: assert property (@(posedge clk) disable iff (rst)
        bad_core |=> err_q);

    // R5: the invalid marker appears only when the bank reports nothing pending
    a_r5_invalid_only_empty: assert property (@(posedge clk) disable iff (rst)
        (claim_rd && claim_data[INVALID_BIT]) |-> !any_all[claim_core]);
endmodule

// File: tb/msivec_ctrl_test.sv
module msivec_ctrl_test;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        deliver_en;
    logic        msi_valid;
    logic [31:0] msi_addr_hi;
    logic [23:0] msi_addr_lo;
    logic        claim_rd;
    logic [1:0]  claim_core;
    logic [31:0] claim_data;
    logic [1:0]  view_core;
    logic [1:0]  view_word;
    logic [63:0] view_data;
    logic [NC-1:0] irq_o;
    logic        err_o;

    always #4 clk = ~clk;   // 125 MHz

    msivec_ctrl #(.NUM_CORES(NC)) uut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    logic [255:0] model [NC];
    logic         merr;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int top_vec(logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic logic [63:0] exp_claim(logic [255:0] b);
        int v = top_vec(b);
        return (v < 0) ? 64'h8000_0000 : 64'(v);
    endfunction

    function automatic logic [23:0] mk_lo(int core, int vec);
        return {core[15:0], vec[7:0]};
    endfunction

    task automatic cycle(bit mv, logic [31:0] hi, int core, int vec,
                         bit cr, int cc, string req);
        int v;
        @(negedge clk);
        msi_valid   = mv;
        msi_addr_hi = hi;
        msi_addr_lo = mk_lo(core, vec);
        claim_rd    = cr;
        claim_core  = cc[1:0];
        #1;
        if (cr) check(req, "claim_data", 64'(claim_data), exp_claim(model[cc]));
        if (cr) begin
            v = top_vec(model[cc]);
            if (v >= 0) model[cc][v] = 1'b0;
        end
        if (mv && hi == 32'hFD) begin
            if (core >= NC) merr = 1'b1;
            else            model[core][vec] = 1'b1;
        end
        @(posedge clk);
        #1;
        msi_valid = 1'b0;
        claim_rd  = 1'b0;
    endtask

    task automatic check_lines(string req);
        logic [NC-1:0] e;
        for (int c = 0; c < NC; c++) e[c] = deliver_en && (model[c] != '0);
        check(req, "irq_o", 64'(irq_o), 64'(e));
        check(req, "err_o", 64'(err_o), 64'(merr));
    endtask

    task automatic check_view(string req);
        for (int c = 0; c < NC; c++) begin
            for (int w = 0; w < 4; w++) begin
                view_core = c[1:0];
                view_word = w[1:0];
                #1;
                check(req, $sformatf("view c%0d w%0d", c, w), view_data, model[c][w*64 +: 64]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; deliver_en = 1'b0; msi_valid = 1'b0; msi_addr_hi = '0;
        msi_addr_lo = '0; claim_rd = 1'b0; claim_core = '0; view_core = '0; view_word = '0;
        merr = 1'b0;
        for (int c = 0; c < NC; c++) model[c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        check_view("R10");
        check_lines("R10");
        // R5: empty claim
        cycle(0, 32'h0, 0, 0, 1, 2, "R5");
        check_view("R5");

        // R11 / R2: capture while delivery disabled
        cycle(1, 32'hFD, 1, 8'h40, 0, 0, "R2");
        check_view("R11");
        check_lines("R11");
        deliver_en = 1'b1;
        #1 check_lines("R6");

        // R1: wrong tag ignored
        cycle(1, 32'hFC, 2, 8'h30, 0, 0, "R1");
        cycle(1, 32'h1FD, 2, 8'h31, 0, 0, "R1");
        check_view("R1");
        check_lines("R1");

        // R3: word boundaries
        cycle(1, 32'hFD, 3, 63, 0, 0, "R3");
        cycle(1, 32'hFD, 3, 64, 0, 0, "R3");
        cycle(1, 32'hFD, 3, 127, 0, 0, "R3");
        cycle(1, 32'hFD, 3, 128, 0, 0, "R3");
        cycle(1, 32'hFD, 3, 191, 0, 0, "R3");
        cycle(1, 32'hFD, 3, 192, 0, 0, "R3");
        cycle(1, 32'hFD, 3, 255, 0, 0, "R3");
        check_view("R3");

        // R4: highest first, cleared one by one
        for (int k = 0; k < 8; k++) cycle(0, 32'h0, 0, 0, 1, 3, "R4");
        check_view("R4");
        check_lines("R6");

        // R7: duplicates merge
        cycle(1, 32'hFD, 0, 200, 0, 0, "R7");
        cycle(1, 32'hFD, 0, 200, 0, 0, "R7");
        cycle(1, 32'hFD, 0, 200, 0, 0, "R7");
        cycle(0, 32'h0, 0, 0, 1, 0, "R7");
        cycle(0, 32'h0, 0, 0, 1, 0, "R7");
        check_view("R7");

        // R8: set and claim of the same vector collide
        cycle(1, 32'hFD, 2, 77, 0, 0, "R8");
        cycle(1, 32'hFD, 2, 77, 1, 2, "R8");
        check_view("R8");
        cycle(0, 32'h0, 0, 0, 1, 2, "R8");
        cycle(0, 32'h0, 0, 0, 1, 2, "R8");

        // R9: core out of range
        cycle(1, 32'hFD, 4, 50, 0, 0, "R9");
        check_view("R9");
        check_lines("R9");
        cycle(0, 32'h0, 0, 0, 0, 0, "R9");
        check_lines("R9");

        // random traffic
        for (int it = 0; it < 600; it++) begin
            int core = $urandom % 5;
            int vec  = 16 + ($urandom % 240);
            int cc   = $urandom % NC;
            bit mv   = ($urandom % 4) != 0;
            bit cr   = ($urandom % 3) == 0;
            logic [31:0] hi = (($urandom % 10) == 0) ? 32'hFC : 32'hFD;
            if (($urandom % 6) == 0) begin
                core = cc;
                vec  = top_vec(model[cc]) < 16 ? vec : top_vec(model[cc]);
                cr   = 1'b1;
            end
            cycle(mv, hi, core, vec, cr, cc, "R4");
            if (it % 50 == 49) deliver_en = ~deliver_en;
            #1 check_lines("R6");
            if (it % 20 == 0) check_view("R2");
        end

        // R10: reset again clears everything
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int c = 0; c < NC; c++) model[c] = '0;
        merr = 1'b0;
        check_view("R10");
        check_lines("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule